// File: doc/BRIEF.md
# Page-Mode DRAM Read Strober

This block turns a one-row read request into the strobe and address waveforms of an asynchronous, address-multiplexed DRAM. A request carries a row address, a list of up to `MAX_COLS` column addresses and a length field. The block puts the row on the shared address pins, pulls the row strobe low, and then issues one column strobe pulse per listed column while the row strobe stays low. Later columns in the same row therefore skip the row access time. Each returned data word is captured and forwarded with a one-cycle valid pulse and the position of its column in the list.

Every strobe width is a cycle count set by a parameter, so the same block fits any clock rate against the device's nanosecond limits. A per-request mode bit chooses where the output enable falls. In early mode it falls before the first column strobe. In late mode it falls a set number of cycles after that strobe. The write strobe never leaves its inactive level. After the last column both strobes return high, and a precharge interval must pass before the next row can be opened. With the default widths the block drives a 256K x 8 part, which has 9 address pins and an 8-bit data bus.

All strobes are active low and come straight from flops. The data pins are inputs only. The device drives them while it is output-enabled and lets them float at all other times.

Top module: `fpm_strober`

## Requirements
- R1: The row address is on `dram_addr` during the cycle before `dram_ras_n` falls. It stays there for `T_RAH` cycles with the row strobe low.
- R2: Each column address reaches `dram_addr` at least one cycle before `dram_cas_n` falls. It is held unchanged while the column strobe is low. The column strobe stays low for exactly `T_CAS` cycles and is only ever low while `dram_ras_n` is low.
- R3: Within a request, `dram_ras_n` stays low across every column pulse. Consecutive pulses are separated by exactly `T_CP` high cycles. Columns are issued in list order, starting with index 0, which is held in bits `[ADDR_W-1:0]` of `req_cols`.
- R4: With `req_late_oe`=0, `dram_oe_n` falls in the column-setup cycle before the first column strobe. With `req_late_oe`=1, it falls `T_OE_LAG` cycles after the first column strobe falls. In both modes it rises together with `dram_ras_n` and is never low while the row strobe is high.
- R5: `dram_we_n` is high at all times.
- R6: `dram_dq` is sampled `T_SAMPLE` cycles after each column strobe falls. In the following cycle `rd_valid` is high for exactly one cycle, with the sampled word on `rd_data` and the list index on `rd_idx`.
- R7: After the last column pulse, both strobes rise together. They stay high for at least `T_RP` cycles before the row strobe falls again. `req_ready` is high only while the block is idle. Request inputs that change while the block is busy do not affect the burst in progress.
- R8: While reset is asserted and right after it, all four strobes are high, `req_ready` is high and `rd_valid` is low.
- R9: A length field of L produces exactly L+1 column pulses and L+1 valid pulses. L=0 gives a single-column access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge if valid |
| req_row | input | ADDR_W | Row address |
| req_cols | input | MAX_COLS*ADDR_W | Column list, index 0 in the low bits |
| req_len | input | IDX_W | Number of columns minus one |
| req_late_oe | input | 1 | 1 selects late output enable |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, held high |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_dq | input | DATA_W | Data from the device |
| rd_valid | output | 1 | Captured word valid, one cycle |
| rd_data | output | DATA_W | Captured word |
| rd_idx | output | IDX_W | List index of the captured word |

## Verification
The sharpest coincidence happens when `T_SAMPLE` equals `T_CAS`. The data capture then falls on the same edge where the column strobe rises, the next column address is loaded, and, on the final column, the row strobe and output enable are released. The bench runs with that setting in both output-enable modes. It judges the result by checking that the captured word matches the column whose strobe just closed, and that `rd_idx` does not already show the next index. A second coincidence comes from holding `req_valid` high through a burst with changing fields. The bench then expects the new row to open on the first edge after `req_ready` returns, with the old burst's addresses untouched.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RSET,
    PH_RHOLD,
    PH_CSET,
    PH_CLOW,
    PH_CHIGH,
    PH_PRE
  } fpm_phase_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned bits_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned cas_pitch(int unsigned t_cas, int unsigned t_cp);
    return t_cas + t_cp;
  endfunction

  function automatic int unsigned first_cas_cycle(int unsigned t_rah);
    return t_rah + 2;
  endfunction

endpackage

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int unsigned T_RAH    = 2,
  parameter int unsigned T_CAS    = 3,
  parameter int unsigned T_CP     = 2,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_OE_LAG = 1,
  parameter int unsigned IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             late_oe,
  input  logic [IDX_W-1:0] last_idx,
  output logic             ras_n,
  output logic             cas_n,
  output logic             oe_n,
  output logic             ready,
  output logic             row_load,
  output logic             col_load,
  output logic [IDX_W-1:0] col_sel,
  output logic [IDX_W-1:0] idx
);

  localparam int unsigned TMR_W = bits_for(max4(T_RAH, T_CAS, T_CP, max4(T_RP, T_OE_LAG, 1, 1)));
  localparam logic [TMR_W-1:0] RAH_LD = TMR_W'(T_RAH - 1);
  localparam logic [TMR_W-1:0] CAS_LD = TMR_W'(T_CAS - 1);
  localparam logic [TMR_W-1:0] CP_LD  = TMR_W'(T_CP - 1);
  localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] OE_LD  = TMR_W'(T_OE_LAG - 1);

  fpm_phase_e       phase;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] oe_cnt;
  logic             oe_wait;
  logic             late_r;
  logic [IDX_W-1:0] last_r;
  logic             tmr_zero;
  logic             last_col;

  always_comb begin
    tmr_zero = (tmr == '0);
    last_col = (idx == last_r);
    ready    = (phase == PH_IDLE);
    row_load = (phase == PH_IDLE) && start;
    col_load = ((phase == PH_RHOLD) && tmr_zero) ||
               ((phase == PH_CLOW) && tmr_zero && !last_col);
    col_sel  = (phase == PH_RHOLD) ? '0 : idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      tmr     <= '0;
      oe_cnt  <= '0;
      oe_wait <= 1'b0;
      late_r  <= 1'b0;
      last_r  <= '0;
      idx     <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      oe_n    <= 1'b1;
    end else begin
      // late output enable countdown from the first column strobe
      if (oe_wait) begin
        if (oe_cnt == '0) begin
          oe_n    <= 1'b0;
          oe_wait <= 1'b0;
        end else begin
          oe_cnt <= oe_cnt - TMR_W'(1);
        end
      end
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_RSET;
            tmr    <= '0;
            idx    <= '0;
            late_r <= late_oe;
            last_r <= last_idx;
          end
        end
        PH_RSET: begin
          phase <= PH_RHOLD;
          ras_n <= 1'b0;
          tmr   <= RAH_LD;
        end
        PH_RHOLD: begin
          if (tmr_zero) begin
            phase <= PH_CSET;
            if (!late_r) oe_n <= 1'b0;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        PH_CSET: begin
          phase <= PH_CLOW;
          cas_n <= 1'b0;
          tmr   <= CAS_LD;
          if (late_r) begin
            oe_wait <= 1'b1;
            oe_cnt  <= OE_LD;
          end
        end
        PH_CLOW: begin
          if (tmr_zero) begin
            cas_n <= 1'b1;
            if (last_col) begin
              phase   <= PH_PRE;
              ras_n   <= 1'b1;
              oe_n    <= 1'b1;
              oe_wait <= 1'b0;
              tmr     <= RP_LD;
            end else begin
              phase <= PH_CHIGH;
              idx   <= idx + IDX_W'(1);
              tmr   <= CP_LD;
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        PH_CHIGH: begin
          if (tmr_zero) begin
            phase <= PH_CLOW;
            cas_n <= 1'b0;
            tmr   <= CAS_LD;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        PH_PRE: begin
          if (tmr_zero) phase <= PH_IDLE;
          else          tmr   <= tmr - TMR_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpm_addr_mux.sv
module fpm_addr_mux #(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned MAX_COLS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       row_load,
  input  logic [ADDR_W-1:0]          row_in,
  input  logic [MAX_COLS*ADDR_W-1:0] cols_in,
  input  logic                       col_load,
  input  logic [IDX_W-1:0]           col_sel,
  output logic [ADDR_W-1:0]          addr
);

  logic [ADDR_W-1:0] col_q [MAX_COLS];

  for (genvar g = 0; g < MAX_COLS; g++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        col_q[g] <= '0;
      else if (row_load) col_q[g] <= cols_in[g*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr <= '0;
    else if (row_load) addr <= row_in;
    else if (col_load) addr <= col_q[col_sel];
  end

endmodule

// File: rtl/fpm_capture.sv
module fpm_capture
  import fpm_pkg::*;
#(
  parameter int unsigned T_CAS    = 3,
  parameter int unsigned T_SAMPLE = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] dq,
  output logic              sample_evt,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx
);

  localparam int unsigned AGE_W = bits_for(T_CAS);
  localparam logic [AGE_W-1:0] SAMPLE_AGE = AGE_W'(T_SAMPLE - 1);

  logic [AGE_W-1:0] age;

  assign sample_evt = !cas_n && (age == SAMPLE_AGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     age <= '0;
    else if (cas_n) age <= '0;
    else            age <= age + AGE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_idx   <= '0;
    end else begin
      rd_valid <= sample_evt;
      if (sample_evt) begin
        rd_data <= dq;
        rd_idx  <= idx;
      end
    end
  end

endmodule

// File: rtl/fpm_strober.sv
module fpm_strober
  import fpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_COLS = 4,
  parameter int unsigned T_RAH    = 2,
  parameter int unsigned T_CAS    = 3,
  parameter int unsigned T_CP     = 2,
  parameter int unsigned T_SAMPLE = 3,
  parameter int unsigned T_OE_LAG = 1,
  parameter int unsigned T_RP     = 3,
  localparam int unsigned IDX_W   = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_row,
  input  logic [MAX_COLS*ADDR_W-1:0] req_cols,
  input  logic [IDX_W-1:0]           req_len,
  input  logic                       req_late_oe,
  output logic                       dram_ras_n,
  output logic                       dram_cas_n,
  output logic                       dram_we_n,
  output logic                       dram_oe_n,
  output logic [ADDR_W-1:0]          dram_addr,
  input  logic [DATA_W-1:0]          dram_dq,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic [IDX_W-1:0]           rd_idx
);

  logic             row_load;
  logic             col_load;
  logic [IDX_W-1:0] col_sel;
  logic [IDX_W-1:0] cur_idx;
  logic             sample_evt;

  assign dram_we_n = 1'b1;

  fpm_seq #(
    .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .T_OE_LAG(T_OE_LAG), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(req_valid), .late_oe(req_late_oe), .last_idx(req_len),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .oe_n(dram_oe_n),
    .ready(req_ready), .row_load(row_load), .col_load(col_load),
    .col_sel(col_sel), .idx(cur_idx)
  );

  fpm_addr_mux #(
    .ADDR_W(ADDR_W), .MAX_COLS(MAX_COLS), .IDX_W(IDX_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .row_load(row_load), .row_in(req_row), .cols_in(req_cols),
    .col_load(col_load), .col_sel(col_sel), .addr(dram_addr)
  );

  fpm_capture #(
    .T_CAS(T_CAS), .T_SAMPLE(T_SAMPLE), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n),
    .cas_n(dram_cas_n), .idx(cur_idx), .dq(dram_dq),
    .sample_evt(sample_evt),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx)
  );

endmodule

// File: rtl/fpm_strober_chk.sv
module fpm_strober_chk #(
  parameter int unsigned T_CAS = 3,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n,
  input logic              dram_oe_n,
  input logic [ADDR_W-1:0] dram_addr,
  input logic              rd_valid,
  input logic              row_load,
  input logic              col_load,
  input logic              sample_evt
);

  logic [15:0] ras_hi;
  logic [15:0] cas_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_hi <= 16'(T_RP);
      cas_lo <= '0;
    end else begin
      if (dram_ras_n) ras_hi <= (ras_hi == 16'hffff) ? ras_hi : ras_hi + 16'd1;
      else            ras_hi <= '0;
      if (!dram_cas_n) cas_lo <= (cas_lo == 16'hffff) ? cas_lo : cas_lo + 16'd1;
      else             cas_lo <= '0;
    end
  end

  a_r1_addr_steady_at_ras_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  a_r1_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |=> dram_ras_n);

  a_r2_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
    col_load |=> dram_cas_n);

  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  a_r2_addr_held_cas_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

  a_r2_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> (cas_lo == 16'(T_CAS)));

  a_r4_oe_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> !dram_ras_n);

  a_r5_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    dram_we_n);

  a_r6_sample_in_cas: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !dram_ras_n);

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi >= 16'(T_RP)));

  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n && dram_oe_n));

endmodule

bind fpm_strober fpm_strober_chk #(
  .T_CAS(T_CAS), .T_RP(T_RP), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
  .rd_valid(rd_valid), .row_load(row_load), .col_load(col_load),
  .sample_evt(sample_evt)
);

// File: tb/fpm_strober_test.sv
module fpm_strober_test;

  localparam int AW = 9, DW = 8, NC = 4;
  localparam int T_RAH = 2, T_CAS = 3, T_CP = 2, T_SAMPLE = 3, T_OE_LAG = 1, T_RP = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [AW-1:0]   req_row = '0;
  logic [NC*AW-1:0] req_cols = '0;
  logic [1:0]      req_len = '0;
  logic            req_late_oe = 1'b0;
  logic            dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [AW-1:0]   dram_addr;
  wire  [DW-1:0]   dram_dq;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;
  logic [1:0]      rd_idx;

  always #4 clk = ~clk;

  fpm_strober #(
    .ADDR_W(AW), .DATA_W(DW), .MAX_COLS(NC), .T_RAH(T_RAH), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_SAMPLE(T_SAMPLE), .T_OE_LAG(T_OE_LAG), .T_RP(T_RP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_cols(req_cols), .req_len(req_len),
    .req_late_oe(req_late_oe), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq(dram_dq), .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx)
  );

  // behavioural memory device
  logic [AW-1:0] lat_row = '0, lat_col = '0;
  function automatic logic [DW-1:0] pat(logic [AW-1:0] r, logic [AW-1:0] c);
    return (r[7:0] + 8'h3b) ^ c[7:0] ^ {c[8], r[8], 6'b0};
  endfunction
  always @(negedge dram_ras_n) lat_row = dram_addr;
  always @(negedge dram_cas_n) lat_col = dram_addr;
  assign dram_dq = (!dram_ras_n && !dram_cas_n && !dram_oe_n) ? pat(lat_row, lat_col) : 8'hzz;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // reference model state
  bit            have = 0;
  int            acc = 0, acc_cnt = 0, rv_seen = 0, m_n = 1;
  bit            m_late = 0;
  logic [AW-1:0] m_row;
  logic [AW-1:0] m_cols [NC];
  bit            m_busy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int d, c0, p, e, ph, kk, k;
      bit e_ras, e_cas, e_oe, e_rv, e_ready;
      e_ras = 1; e_cas = 1; e_oe = 1; e_rv = 0; e_ready = 1; kk = 0;
      if (rd_valid) rv_seen++;
      if (have && cyc >= acc) begin
        d  = cyc - acc;
        c0 = T_RAH + 2;
        p  = T_CAS + T_CP;
        e  = c0 + (m_n - 1) * p + T_CAS;
        e_ready = (d >= e + T_RP);
        e_ras = !(d >= 1 && d < e);
        e_oe  = !(d >= (m_late ? c0 + T_OE_LAG : T_RAH + 1) && d < e);
        if (d >= c0 && d < e) begin
          ph = (d - c0) % p;
          if (ph < T_CAS) e_cas = 0;
        end
        if (d >= c0 && (d - c0) % p == T_SAMPLE && (d - c0) / p < m_n) begin
          e_rv = 1;
          kk = (d - c0) / p;
        end
        if (d <= T_RAH) chk("R1 row address", dram_addr, m_row);
        else if (d < e) begin
          if (d < c0) k = 0;
          else k = (d - c0) / p + (((d - c0) % p >= T_CAS) ? 1 : 0);
          chk("R3 column address order", dram_addr, m_cols[k]);
        end
      end
      m_busy = !e_ready;
      chk("R3 ras_n", dram_ras_n, e_ras);
      chk("R2 cas_n", dram_cas_n, e_cas);
      chk("R4 oe_n", dram_oe_n, e_oe);
      chk("R5 we_n", dram_we_n, 1);
      chk("R7 req_ready", req_ready, e_ready);
      chk("R6 rd_valid", rd_valid, e_rv);
      if (e_rv && rd_valid) begin
        chk("R6 rd_data", rd_data, pat(m_row, m_cols[kk]));
        chk("R6 rd_idx", rd_idx, kk);
      end
      if (e_ready && req_valid) begin
        if (have) chk("R9 valid pulse count", rv_seen, m_n);
        rv_seen = 0;
        have = 1;
        acc = cyc + 1;
        m_row = req_row;
        for (int i = 0; i < NC; i++) m_cols[i] = req_cols[i*AW +: AW];
        m_n = int'(req_len) + 1;
        m_late = req_late_oe;
        m_busy = 1;
        acc_cnt++;
      end
    end
  end

  task automatic issue(logic [AW-1:0] row, logic [AW-1:0] c0, logic [AW-1:0] c1,
                       logic [AW-1:0] c2, logic [AW-1:0] c3, int len, bit late);
    int start;
    start = acc_cnt;
    req_row = row;
    req_cols = {c3, c2, c1, c0};
    req_len = 2'(len);
    req_late_oe = late;
    req_valid = 1'b1;
    wait (acc_cnt != start);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 ras_n in reset", dram_ras_n, 1);
    chk("R8 cas_n in reset", dram_cas_n, 1);
    chk("R8 oe_n in reset", dram_oe_n, 1);
    chk("R8 ready in reset", req_ready, 1);
    chk("R8 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 ras_n after reset", dram_ras_n, 1);

    // early read, full list
    issue(9'h155, 9'h003, 9'h004, 9'h1f0, 9'h0aa, 3, 0);
    wait_idle();
    chk("R9 four columns", rv_seen, 4);

    // late read, single column (length 0)
    issue(9'h0aa, 9'h101, 9'h000, 9'h000, 9'h000, 0, 1);
    wait_idle();
    chk("R9 single column", rv_seen, 1);

    // late read of three, then request held and churned while busy (R7)
    issue(9'h1ff, 9'h1ff, 9'h000, 9'h080, 9'h111, 2, 1);
    req_valid = 1'b1;
    req_late_oe = 1'b0;
    req_len = 2'd1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (m_busy) begin
        req_row = 9'(9'h0f0 + i);
        req_cols = {NC{9'(9'h033 + 3 * i)}};
      end
    end
    issue(9'h000, 9'h1fe, 9'h001, 9'h002, 9'h003, 1, 0);
    wait_idle();
    chk("R9 two columns", rv_seen, 2);

    // back-to-back with valid held through precharge
    issue(9'h123, 9'h010, 9'h020, 9'h030, 9'h040, 3, 1);
    req_valid = 1'b1;
    req_row = 9'h0c3; req_cols = {9'h044, 9'h033, 9'h022, 9'h011}; req_len = 2'd2; req_late_oe = 1'b0;
    issue(9'h0c3, 9'h011, 9'h022, 9'h033, 9'h044, 2, 0);
    wait_idle();
    chk("R9 three columns", rv_seen, 3);
    chk("R7 idle ready", req_ready, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule